// File: doc/BRIEF.md
# RAM-based long shift register

This block is a long bit-serial delay line. It is built from several cascaded single-port memory segments instead of a chain of flip-flops. One wrapping address counter is shared by every segment. On each accepted sample tick, a four-phase sequencer runs once:

- It advances the counter.
- It reads the old bit at the new address of every segment.
- It writes each segment's incoming bit back to that same address.
- It latches the output of the last segment onto the serial output.

The first segment takes the line input. Each later segment takes the bit that was just read from the segment before it. A bit therefore spends exactly one full counter cycle in each segment. The line length is the product of the segment count and the segment depth, and it is counted in sample ticks, not clock cycles.

The memory content after reset is undefined. The block therefore keeps its serial output at zero and its valid flag low until a full line length of ticks has been written. From then on the output is always meaningful.

Top module: `dly_bitline`

## Requirements
- R1: While reset is asserted and directly after its release, `dout_o` is 0 and `dout_valid_o` is 0.
- R2: With N = NUM_SEG*SEG_DEPTH, after the sequence started by the k-th accepted tick (k counted from 0), `dout_o` equals the `din_i` value sampled with tick k-N. This holds for any number of idle clock cycles between ticks.
- R3: `dout_valid_o` rises at the end of the sequence of accepted tick N and then stays 1 until reset. While it is 0, `dout_o` stays 0.
- R4: A tick sampled at clock edge E starts a sequence of four phases: advance, read, write, latch. `dout_o` can change only at edge E+4 and holds its value at edges E+1 to E+3.
- R5: A `tick_i` pulse that arrives while a sequence is in progress has no effect: it is not stored and does not extend the line.
- R6: The shared address wraps to 0 after SEG_DEPTH advances. In each segment the old bit is read before the new bit is written at the same address, so each segment delays by exactly SEG_DEPTH ticks. A single 1 in a stream of 0s appears after exactly N ticks.
- R7: Without ticks, `dout_o` and `dout_valid_o` hold their values for any number of clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sample tick; a one-cycle pulse starts one line step |
| din_i | input | 1 | Serial data input, sampled together with an accepted tick |
| dout_o | output | 1 | Serial data output, delayed by N ticks |
| dout_valid_o | output | 1 | High once a full line length has been written |

## Verification
The hardest case to reach from the ports is a tick that lands inside a running sequence. An ignored tick is invisible unless the bench later sees that the delay did not shrink by one. The stimulus therefore injects extra `tick_i` pulses one cycle after an accepted tick, at random points of a long random stream. The bench model keeps stepping only on accepted ticks, so any accepted stray tick shows up as a shifted bit on every comparison that follows. The exact segment length is checked with a lone 1 injected during the first fill. Random idle gaps between ticks show that the delay counts ticks and not clock cycles.

// File: rtl/dly_pkg.sv
package dly_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADV   = 3'd1,
        PH_READ  = 3'd2,
        PH_WRITE = 3'd3,
        PH_LATCH = 3'd4
    } phase_e;

    function automatic int addr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/dly_phase_seq.sv
module dly_phase_seq
    import dly_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   tick_i,
    output logic   accept_o,
    output logic   adv_o,
    output logic   rd_o,
    output logic   wr_o,
    output logic   latch_o,
    output phase_e phase_o
);

    typedef struct packed {
        phase_e phase;
    } seq_state_t;

    seq_state_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_IDLE:  if (tick_i) seq_d.phase = PH_ADV;
            PH_ADV:   seq_d.phase = PH_READ;
            PH_READ:  seq_d.phase = PH_WRITE;
            PH_WRITE: seq_d.phase = PH_LATCH;
            PH_LATCH: seq_d.phase = PH_IDLE;
            default:  seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '{phase: PH_IDLE};
        else         seq_q <= seq_d;
    end

    assign accept_o = tick_i && (seq_q.phase == PH_IDLE);
    assign adv_o    = (seq_q.phase == PH_ADV);
    assign rd_o     = (seq_q.phase == PH_READ);
    assign wr_o     = (seq_q.phase == PH_WRITE);
    assign latch_o  = (seq_q.phase == PH_LATCH);
    assign phase_o  = seq_q.phase;

    // R4
    phase_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.phase == PH_READ) |-> ($past(seq_q.phase) == PH_ADV));

    // R5
    busy_tick_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && seq_q.phase != PH_IDLE) |=> (seq_q.phase != PH_ADV));

endmodule

// File: rtl/dly_addr_ctr.sv
module dly_addr_ctr #(
    parameter int DEPTH = 16,
    parameter int AW    = dly_pkg::addr_bits(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          adv_i,
    output logic [AW-1:0] addr_o
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
    } ctr_state_t;

    ctr_state_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (adv_i) begin
            if (ctr_q.addr == LAST) ctr_d.addr = '0;
            else                    ctr_d.addr = ctr_q.addr + AW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctr_q <= '{addr: '0};
        else         ctr_q <= ctr_d;
    end

    assign addr_o = ctr_q.addr;

    // R6
    addr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && ctr_q.addr == LAST) |=> (ctr_q.addr == '0));

    // R6
    addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && ctr_q.addr != LAST) |=> (ctr_q.addr == $past(ctr_q.addr) + AW'(1)));

    // R7
    addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adv_i |=> $stable(ctr_q.addr));

endmodule

// File: rtl/dly_ram_seg.sv
module dly_ram_seg #(
    parameter int DEPTH = 16,
    parameter int AW    = dly_pkg::addr_bits(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic          din_i,
    output logic          dout_o
);

    logic [DEPTH-1:0] mem_q;

    typedef struct packed {
        logic rbit;
    } seg_state_t;

    seg_state_t seg_d, seg_q;

    always_comb begin
        seg_d = seg_q;
        if (rd_i) seg_d.rbit = mem_q[addr_i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seg_q <= '{rbit: 1'b0};
        else         seg_q <= seg_d;
    end

    always_ff @(posedge clk_i) begin
        if (wr_i) mem_q[addr_i] <= din_i;
    end

    assign dout_o = seg_q.rbit;

    // R6
    read_before_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |-> $past(rd_i));

    // R6
    same_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_i |=> (wr_i && $stable(addr_i)));

endmodule

// File: rtl/dly_fill_ctr.sv
module dly_fill_ctr #(
    parameter int LEN = 64,
    parameter int CW  = $clog2(LEN + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic latch_i,
    output logic load_o,
    output logic valid_o
);

    localparam logic [CW-1:0] FULL = CW'(LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          valid;
    } fill_state_t;

    fill_state_t fill_d, fill_q;

    always_comb begin
        fill_d = fill_q;
        if (latch_i) begin
            if (fill_q.cnt == FULL) fill_d.valid = 1'b1;
            else                    fill_d.cnt   = fill_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fill_q <= '{cnt: '0, valid: 1'b0};
        else         fill_q <= fill_d;
    end

    assign load_o  = latch_i && (fill_q.cnt == FULL);
    assign valid_o = fill_q.valid;

    // R3
    valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_q.valid |=> fill_q.valid);

    // R3
    valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fill_q.valid) |-> ($past(latch_i) && $past(fill_q.cnt) == FULL));

endmodule

// File: rtl/dly_bitline.sv
module dly_bitline
    import dly_pkg::*;
#(
    parameter int NUM_SEG   = 4,
    parameter int SEG_DEPTH = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic din_i,
    output logic dout_o,
    output logic dout_valid_o
);

    localparam int LINE_LEN = NUM_SEG * SEG_DEPTH;
    localparam int AW       = addr_bits(SEG_DEPTH);

    logic          accept, adv, rd, wr, latch, load;
    phase_e        phase;
    logic [AW-1:0] addr;
    logic [NUM_SEG-1:0] seg_in, seg_rd;

    typedef struct packed {
        logic in_bit;
        logic dout;
    } top_state_t;

    top_state_t top_d, top_q;

    dly_phase_seq i_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .accept_o (accept),
        .adv_o    (adv),
        .rd_o     (rd),
        .wr_o     (wr),
        .latch_o  (latch),
        .phase_o  (phase)
    );

    dly_addr_ctr #(.DEPTH(SEG_DEPTH), .AW(AW)) i_addr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .adv_i  (adv),
        .addr_o (addr)
    );

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        if (g == 0) begin : g_head
            assign seg_in[g] = top_q.in_bit;
        end else begin : g_link
            assign seg_in[g] = seg_rd[g-1];
        end
        dly_ram_seg #(.DEPTH(SEG_DEPTH), .AW(AW)) i_ram (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .rd_i   (rd),
            .wr_i   (wr),
            .addr_i (addr),
            .din_i  (seg_in[g]),
            .dout_o (seg_rd[g])
        );
    end

    dly_fill_ctr #(.LEN(LINE_LEN)) i_fill (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .latch_i (latch),
        .load_o  (load),
        .valid_o (dout_valid_o)
    );

    always_comb begin
        top_d = top_q;
        if (accept) top_d.in_bit = din_i;
        if (load)   top_d.dout   = seg_rd[NUM_SEG-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) top_q <= '{in_bit: 1'b0, dout: 1'b0};
        else         top_q <= top_d;
    end

    assign dout_o = top_q.dout;

    // R4
    dout_latch_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(top_q.dout) |-> $past(phase == PH_LATCH));

    // R3
    dout_zero_unfilled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dout_valid_o |-> !top_q.dout);

    // R7
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(phase) == PH_IDLE) |-> ($stable(top_q.dout) && $stable(dout_valid_o)));

endmodule

// File: tb/test_dly_bitline.sv
`timescale 1ns/1ps
module test_dly_bitline;

    localparam int NUM_SEG   = 4;
    localparam int SEG_DEPTH = 16;
    localparam int N         = NUM_SEG * SEG_DEPTH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic din = 1'b0;
    logic dout, dvalid;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit hist[$];
    logic last_dout = 1'b0;

    always #2.5 clk = ~clk;

    dly_bitline #(.NUM_SEG(NUM_SEG), .SEG_DEPTH(SEG_DEPTH)) i_dly_bitline (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tick_i       (tick),
        .din_i        (din),
        .dout_o       (dout),
        .dout_valid_o (dvalid)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (tick %0d)", req, act, exp, hist.size());
        end
    endtask

    function automatic logic exp_valid(input int k);
        return (k >= N);
    endfunction

    function automatic logic exp_dout(input int k);
        return (k >= N) ? hist[k-N] : 1'b0;
    endfunction

    // One accepted tick with bit b; poke adds a tick while the sequence runs.
    task automatic step(input logic b, input bit poke, input string tag);
        int k;
        @(negedge clk); tick = 1'b1; din = b;
        @(negedge clk); tick = poke; din = 1'($urandom);
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R4 hold before latch", dout, last_dout);
        @(negedge clk);
        hist.push_back(b);
        k = hist.size() - 1;
        check({tag, " data"}, dout, exp_dout(k));
        check("R3 valid", dvalid, exp_valid(k));
        last_dout = dout;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 dout in reset", dout, 1'b0);
        check("R1 valid in reset", dvalid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 dout after reset", dout, 1'b0);
        check("R1 valid after reset", dvalid, 1'b0);
        hist.delete();
        last_dout = 1'b0;
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        do_reset();

        // R6: lone 1 during first fill, must leave at exactly tick N
        for (int i = 0; i < N + 4; i++) begin
            if (i == N - 1 || i == N || i == N + 1)
                step(1'b0 | (i == 0), 1'b0, "R6 impulse");
            else
                step(logic'(i == 0), 1'b0, "R2 fill");
        end

        // R2 / R5: random data, random idle gaps, stray ticks during sequences
        for (int i = 0; i < 400; i++) begin
            bit poke;
            poke = ($urandom % 5) == 0;
            step(1'($urandom), poke, poke ? "R5 stray tick" : "R2 random");
            repeat ($urandom % 7) @(negedge clk);
        end

        // R7: long idle, outputs hold
        begin
            logic d0, v0;
            d0 = dout; v0 = dvalid;
            repeat (50) @(negedge clk);
            check("R7 dout idle", dout, d0);
            check("R7 valid idle", dvalid, v0);
        end

        // R2: alternating and constant runs
        for (int i = 0; i < 2 * N; i++) step(logic'(i[0]), 1'b0, "R2 alternating");
        for (int i = 0; i < N + 8; i++) step(1'b1, 1'b0, "R2 ones");

        // R1/R3: reset mid-run, valid drops and refills
        do_reset();
        for (int i = 0; i < N + 10; i++) step(1'($urandom), (i % 3) == 1, "R3 refill");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule